// File: doc/BRIEF.md
# Optical Focus Search Controller

This block runs the focus acquisition sequence of an optical disc pickup. On a start command it sweeps the focus actuator with a digital triangle ramp. The ramp moves by a programmable step on each servo tick and turns around at programmable lower and upper limits. A rising ramp means the lens is travelling toward the disc from its far position.

While sweeping, the block watches a signed focus-error sample and an RF-present flag. It closes the focus loop on the first tick where three things are true together: the lens is rising, RF is present, and the focus error has crossed zero. A zero crossing means the sample left a hysteresis band on one side and now lies outside it on the other side. Focus-error samples taken during a blind period just after start are ignored. A blank mirror area still reports RF present, so closing there is allowed.

Once closed, the search status bit drops and the loop-close enable rises. After a programmable number of ticks, RF presence is sampled again. If RF is absent, the loop is opened and a lock-failure flag is raised. If no crossing is accepted within a programmable number of sweeps, the search stops and a timeout flag is set.

Top module: `focus_acq_ctrl`

## Requirements
- R1: After reset, drive is 0 and searching, loop_close, lock_fail and search_timeout are all 0.
- R2: One cycle after start is high, searching is 1, loop_close is 0, drive equals lim_lo and the ramp direction is rising. Start takes priority over tick.
- R3: While searching, each cycle with tick high moves drive by +step when rising and by -step when falling. A move that would reach or pass lim_hi gives exactly lim_hi and turns the ramp to falling. A move that would reach or pass lim_lo gives exactly lim_lo and turns it to rising. In cycles without tick, drive does not change.
- R4: During the first blind_ticks ticks after start, fe_sample is ignored: no close can happen, and no zero-crossing history is kept from those samples.
- R5: The zone of a sample is positive when fe_sample >= hyst and negative when fe_sample <= -hyst. A sample inside the band neither counts as a crossing nor changes the remembered zone. A crossing is a sample whose zone is the opposite of the last remembered zone.
- R6: The loop closes on a tick only when a crossing (R5) occurs, the ramp is rising and rf_ok is high. In the next cycle searching is 0, loop_close is 1, and drive holds the value it had before that tick. A crossing while the ramp falls does not close the loop.
- R7: On the verify_ticks-th tick after closing (at least one), rf_ok is sampled. If it is low, loop_close goes to 0, drive goes to 0 and lock_fail goes to 1 in the next cycle. If it is high, loop_close stays 1 and drive stays frozen.
- R8: Each return of the falling ramp to lim_lo completes a sweep. When the sweep_max-th sweep completes, searching goes to 0, drive goes to 0 and search_timeout goes to 1.
- R9: A start from any state restarts the search and clears lock_fail and search_timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart the focus search |
| tick | input | 1 | Servo sample strobe, one cycle wide |
| fe_sample | input | EW | Signed focus-error sample |
| rf_ok | input | 1 | RF signal present |
| step | input | DW-1 | Ramp increment per tick |
| lim_lo | input | DW | Signed lower ramp limit (far from disc) |
| lim_hi | input | DW | Signed upper ramp limit (near disc) |
| sweep_max | input | SW | Sweeps allowed before timeout |
| blind_ticks | input | CW | Ticks of ignored focus error after start |
| verify_ticks | input | CW | Ticks from loop close to the lock check |
| hyst | input | EW-1 | Half-width of the zero-crossing band |
| drive | output | DW | Signed focus actuator search command |
| searching | output | 1 | Focus search in progress |
| loop_close | output | 1 | Focus loop closed |
| lock_fail | output | 1 | Lock check found no RF |
| search_timeout | output | 1 | Search gave up after sweep_max sweeps |

## Verification
A wrong ramp direction or sweep count shows on drive at the next tick. A wrong limit turnaround appears as a value past a limit, and a miscounted sweep makes search_timeout fire twenty ticks early or late with the bench settings. A stale zone register or blind counter shows as a close one tick too early, too late or never, so searching and loop_close are checked right after every tick of the closing sequence. A misloaded verify counter moves the lock_fail edge away from the exact tick where the bench drops rf_ok.

// File: rtl/focus_acq_ctrl.sv
module focus_acq_ctrl #(
  parameter int DW = 12,
  parameter int EW = 12,
  parameter int CW = 16,
  parameter int SW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 tick,
  input  logic signed [EW-1:0] fe_sample,
  input  logic                 rf_ok,
  input  logic        [DW-2:0] step,
  input  logic signed [DW-1:0] lim_lo,
  input  logic signed [DW-1:0] lim_hi,
  input  logic        [SW-1:0] sweep_max,
  input  logic        [CW-1:0] blind_ticks,
  input  logic        [CW-1:0] verify_ticks,
  input  logic        [EW-2:0] hyst,
  output logic signed [DW-1:0] drive,
  output logic                 searching,
  output logic                 loop_close,
  output logic                 lock_fail,
  output logic                 search_timeout
);

  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_VERIFY, S_LOCK} state_t;
  localparam logic [1:0] Z_NONE = 2'd0;
  localparam logic [1:0] Z_NEG  = 2'd1;
  localparam logic [1:0] Z_POS  = 2'd2;
  localparam logic [CW-1:0] C_ONE = CW'(1);
  localparam logic [SW-1:0] S_ONE = SW'(1);

  state_t        state;
  logic          dir_up;
  logic [1:0]    zone;
  logic [CW-1:0] bcnt;
  logic [CW-1:0] vcnt;
  logic [SW-1:0] sweeps;

  logic signed [EW-1:0] hyst_s;
  logic [1:0]           zone_now;
  logic                 crossing, blind, close_ok, up_hit, dn_hit;
  logic signed [DW:0]   up_sum, dn_sum, hi_x, lo_x;
  logic [SW-1:0]        sweeps_nx;

  assign hyst_s    = $signed({1'b0, hyst});
  assign zone_now  = (fe_sample >= hyst_s)  ? Z_POS :
                     (fe_sample <= -hyst_s) ? Z_NEG : Z_NONE;
  assign crossing  = (zone != Z_NONE) && (zone_now != Z_NONE) && (zone_now != zone);
  assign blind     = (bcnt != '0);
  assign close_ok  = (state == S_SEARCH) && !blind && dir_up && rf_ok && crossing;

  assign up_sum    = $signed({drive[DW-1], drive}) + $signed({2'b00, step});
  assign dn_sum    = $signed({drive[DW-1], drive}) - $signed({2'b00, step});
  assign hi_x      = $signed({lim_hi[DW-1], lim_hi});
  assign lo_x      = $signed({lim_lo[DW-1], lim_lo});
  assign up_hit    = (up_sum >= hi_x);
  assign dn_hit    = (dn_sum <= lo_x);
  assign sweeps_nx = sweeps + S_ONE;

  assign searching  = (state == S_SEARCH);
  assign loop_close = (state == S_VERIFY) || (state == S_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      drive          <= '0;
      dir_up         <= 1'b1;
      zone           <= Z_NONE;
      bcnt           <= '0;
      vcnt           <= '0;
      sweeps         <= '0;
      lock_fail      <= 1'b0;
      search_timeout <= 1'b0;
    end else if (start) begin
      state          <= S_SEARCH;
      drive          <= lim_lo;
      dir_up         <= 1'b1;
      zone           <= Z_NONE;
      bcnt           <= blind_ticks;
      sweeps         <= '0;
      lock_fail      <= 1'b0;
      search_timeout <= 1'b0;
    end else if (tick) begin
      case (state)
        S_SEARCH: begin
          if (close_ok) begin
            state <= S_VERIFY;
            vcnt  <= verify_ticks;
          end else begin
            if (blind) begin
              bcnt <= bcnt - C_ONE;
              zone <= Z_NONE;
            end else if (zone_now != Z_NONE) begin
              zone <= zone_now;
            end
            if (dir_up) begin
              if (up_hit) begin
                drive  <= lim_hi;
                dir_up <= 1'b0;
              end else begin
                drive <= up_sum[DW-1:0];
              end
            end else if (dn_hit) begin
              if (sweeps_nx >= sweep_max) begin
                state          <= S_IDLE;
                drive          <= '0;
                search_timeout <= 1'b1;
              end else begin
                drive  <= lim_lo;
                dir_up <= 1'b1;
                sweeps <= sweeps_nx;
              end
            end else begin
              drive <= dn_sum[DW-1:0];
            end
          end
        end
        S_VERIFY: begin
          if (vcnt <= C_ONE) begin
            if (rf_ok) begin
              state <= S_LOCK;
            end else begin
              state     <= S_IDLE;
              drive     <= '0;
              lock_fail <= 1'b1;
            end
          end else begin
            vcnt <= vcnt - C_ONE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/focus_acq_ctrl_chk.sv
module focus_acq_ctrl_chk #(
  parameter int DW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 tick,
  input logic                 rf_ok,
  input logic signed [DW-1:0] drive,
  input logic signed [DW-1:0] lim_lo,
  input logic signed [DW-1:0] lim_hi,
  input logic                 searching,
  input logic                 loop_close,
  input logic                 lock_fail,
  input logic                 search_timeout
);

  p_close_needs_rf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_close) |-> ($past(rf_ok) && $past(tick)));

  p_search_excl_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(searching && loop_close));

  p_drive_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_close && $past(loop_close)) |-> $stable(drive));

  p_drive_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    searching |-> (drive >= lim_lo && drive <= lim_hi));

  p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(start)) |-> $stable(drive));

  p_fail_on_no_rf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_fail) |-> (!$past(rf_ok) && $fell(loop_close)));

  p_timeout_ends_search_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(search_timeout) |-> $fell(searching));

endmodule

bind focus_acq_ctrl focus_acq_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/focus_acq_ctrl_bench.sv
module focus_acq_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int DW = 12, EW = 12, CW = 16, SW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0, rf_ok = 1'b0;
  logic signed [EW-1:0] fe_sample = '0;
  logic [DW-2:0] step = 11'd10;
  logic signed [DW-1:0] lim_lo = -12'sd50, lim_hi = 12'sd50;
  logic [SW-1:0] sweep_max = 8'd2;
  logic [CW-1:0] blind_ticks = 16'd3, verify_ticks = 16'd4;
  logic [EW-2:0] hyst = 11'd8;
  logic signed [DW-1:0] drive;
  logic searching, loop_close, lock_fail, search_timeout;

  int checks = 0, failures = 0;

  focus_acq_ctrl #(.DW(DW), .EW(EW), .CW(CW), .SW(SW)) u_focus_acq_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .fe_sample(fe_sample),
    .rf_ok(rf_ok), .step(step), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .sweep_max(sweep_max), .blind_ticks(blind_ticks), .verify_ticks(verify_ticks),
    .hyst(hyst), .drive(drive), .searching(searching), .loop_close(loop_close),
    .lock_fail(lock_fail), .search_timeout(search_timeout));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_tick(input int fe, input logic rf);
    fe_sample = EW'(fe);
    rf_ok = rf;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic close_seq();
    do_tick(-20, 1'b1);
    do_tick(20, 1'b1);
    do_tick(-20, 1'b1);
    chk("R4 no close in blind period", int'(searching), 1);
    do_tick(20, 1'b1);
    do_tick(-20, 1'b0);
    chk("R6 no close with rf_ok low", int'(loop_close), 0);
    do_tick(3, 1'b1);
    chk("R5 in-band sample ignored", int'(loop_close), 0);
    chk("R3 ramp value before close", int'(drive), 10);
    do_tick(20, 1'b1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 drive", int'(drive), 0);
    chk("R1 searching", int'(searching), 0);
    chk("R1 loop_close", int'(loop_close), 0);
    chk("R1 flags", int'({lock_fail, search_timeout}), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_close_then_fail();
    do_start();
    chk("R2 searching after start", int'(searching), 1);
    chk("R2 drive at lim_lo", int'(drive), -50);
    close_seq();
    chk("R6 searching fell on close", int'(searching), 0);
    chk("R6 loop_close rose", int'(loop_close), 1);
    chk("R6 drive frozen", int'(drive), 10);
    repeat (3) do_tick(0, 1'b1);
    chk("R7 still closed before check tick", int'(loop_close), 1);
    do_tick(0, 1'b0);
    chk("R7 lock_fail on rf low", int'(lock_fail), 1);
    chk("R7 loop opened", int'(loop_close), 0);
    chk("R7 drive cleared", int'(drive), 0);
  endtask

  task automatic t_close_then_lock();
    do_start();
    chk("R9 lock_fail cleared by start", int'(lock_fail), 0);
    close_seq();
    repeat (4) do_tick(0, 1'b1);
    repeat (3) do_tick(40, 1'b0);
    chk("R7 lock held", int'(loop_close), 1);
    chk("R7 no lock_fail", int'(lock_fail), 0);
    chk("R6 drive still frozen", int'(drive), 10);
  endtask

  task automatic t_falling_no_close();
    do_start();
    repeat (10) do_tick(0, 1'b1);
    chk("R3 turnaround at lim_hi", int'(drive), 50);
    do_tick(20, 1'b1);
    do_tick(-20, 1'b1);
    chk("R6 no close while falling", int'(searching), 1);
    chk("R3 falling ramp", int'(drive), 30);
    do_tick(20, 1'b1);
    chk("R6 no close while falling 2", int'(loop_close), 0);
  endtask

  task automatic t_tick_gate();
    do_start();
    do_tick(0, 1'b1);
    repeat (5) @(negedge clk);
    chk("R3 no move without tick", int'(drive), -40);
  endtask

  task automatic t_timeout();
    do_start();
    repeat (20) do_tick(0, 1'b1);
    chk("R3 back at lim_lo after one sweep", int'(drive), -50);
    chk("R8 still searching after sweep 1", int'(searching), 1);
    repeat (19) do_tick(0, 1'b1);
    chk("R3 ramp before final step", int'(drive), -40);
    do_tick(0, 1'b1);
    chk("R8 timeout set", int'(search_timeout), 1);
    chk("R8 search stopped", int'(searching), 0);
    chk("R8 drive cleared", int'(drive), 0);
    do_start();
    chk("R9 timeout cleared", int'(search_timeout), 0);
    chk("R9 restarted", int'(searching), 1);
  endtask

  task automatic t_clamp();
    step = 11'd30;
    do_start();
    repeat (3) do_tick(0, 1'b1);
    chk("R3 step 30 third tick", int'(drive), 40);
    do_tick(0, 1'b1);
    chk("R3 clamp to lim_hi", int'(drive), 50);
    do_tick(0, 1'b1);
    chk("R3 falling after clamp", int'(drive), 20);
    step = 11'd10;
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_close_then_fail();
    t_close_then_lock();
    t_falling_no_close();
    t_tick_gate();
    t_timeout();
    t_clamp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule